// File: doc/BRIEF.md
# Column Burst Sequencer

This block sits in a synchronous DRAM controller behind the command path and in front of the column logic. Once a row is already open, it takes each read or write command, works out the column address for every beat of the burst, and raises the matching per-cycle enables. It takes the commands from four active-low strobe pins, a bank bit and a column field. The burst length, the beat order and the read latency come from static mode inputs.

A read puts out a column on every beat. Each beat also enters a latency pipeline, so the read output enable rises CAS-latency cycles later. A write raises its input enable in the command cycle itself, and that first beat carries data. A new command landing on the cycle after the last beat keeps the beats, and the read enable, free of gaps. The block also reports whether the write-recovery time since the last write beat has run out, so the controller can tell when a precharge is allowed.

The block has no data path and no back-pressure. Commands are taken on every edge. The enables are plain qualifiers that the datapath must follow on the cycle they are given, so the block needs no valid/ready handshake.

Top module: `burst_seq`

## Requirements
- R1: With `cs_n`=0 and strobes (`ras_n`,`cas_n`,`we_n`) = (1,0,1) a read starts, and with (1,0,0) a write starts. Precharge is (0,1,0) and burst stop is (1,1,0). Any cycle with `cs_n`=1 is a no-operation.
- R2: The beat length comes from `bl_sel`: values 0 to 3 give 1, 2, 4 and 8 beats. In sequential order (`ilv`=0), beat k puts out the start column with its low log2(length) bits replaced by (low bits + k) modulo the length. The upper bits stay fixed, so exactly length beats are issued.
- R3: With `ilv`=1 and a finite length, beat k replaces the low bits by (low bits XOR k).
- R4: Each read beat raises `rd_oe` exactly `cas_lat` cycles later. The values of `cas_lat` run from 1 to MAX_CL.
- R5: A write raises `wr_en` with the start column in the command cycle. `wr_en` falls after the last beat of the programmed length.
- R6: A read issued in the cycle right after the last beat of a read continues `col_out`/`rd_issue`, and `rd_oe`, with no idle cycle.
- R7: A read or write that arrives during a burst ends that burst and starts its own first beat in the same cycle.
- R8: A precharge to the bank of the running burst ends the burst, with no beat in the precharge cycle. A precharge to the other bank has no effect.
- R9: A burst stop ends the burst, with no beat in that cycle, only when `bl_sel[2]`=1 (full page). With a finite length it is ignored.
- R10: In full-page mode the column counts up by one each cycle, wraps over the whole column space and never ends by itself.
- R11: `wr_rec_ok` is low during a write beat. After the last write beat at cycle W it rises at cycle W+TRDL.
- R12: After reset `rd_issue`, `wr_en` and `rd_oe` are low and `wr_rec_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| bank | input | 1 | Bank of the command |
| col_in | input | COL_W | Start column of a read or write |
| bl_sel | input | 3 | Burst length select; bit 2 picks full page |
| ilv | input | 1 | Interleaved beat order when high |
| cas_lat | input | $clog2(MAX_CL+1) | Read latency in cycles |
| col_out | output | COL_W | Column of the current beat |
| beat_bank | output | 1 | Bank of the current beat |
| rd_issue | output | 1 | A read beat is issued this cycle |
| wr_en | output | 1 | Write input enable, data of this beat is captured |
| rd_oe | output | 1 | Read data output enable |
| wr_rec_ok | output | 1 | Write recovery satisfied, precharge allowed |

## Verification
A beat issued by a command is due in the command cycle itself, because `col_out`, `rd_issue` and `wr_en` follow the pins combinationally. The beat k of a burst is due k cycles after its command. `rd_oe` is due `cas_lat` cycles after each read beat, and `wr_rec_ok` rises TRDL cycles after the last write beat. The bench drives each command on a falling edge and samples one nanosecond later, within the same cycle. It counts cycle c from the command, and its expected values are formulas in c, the start column, the length and the latency. The sweep covers every finite length, both orders, every latency and several start columns, for reads and for writes. Directed sequences then place a second command at an exact cycle offset to test chaining and termination.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_STOP
  } cmd_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
  import burst_seq_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b110:  cmd = CMD_STOP;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [2:0]       bl_sel,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] low;
  logic             full;

  always_comb begin
    full = bl_sel[2];
    mask = full ? '1 : ((COL_W'(1) << bl_sel[1:0]) - COL_W'(1));
    low  = (ilv && !full) ? (base ^ beat) : (base + beat);
    col  = (base & ~mask) | (low & mask);
  end
endmodule

// File: rtl/burst_lat_pipe.sv
module burst_lat_pipe #(
  parameter int MAX_CL = 3,
  localparam int CLW = $clog2(MAX_CL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  input  logic [CLW-1:0] cl,
  output logic           dout
);
  logic [MAX_CL-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[MAX_CL-2:0], din};
  end

  always_comb begin
    if (int'(cl) == 0)           dout = stg[0];
    else if (int'(cl) > MAX_CL)  dout = stg[MAX_CL-1];
    else                         dout = stg[int'(cl) - 1];
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3,
  parameter int TRDL   = 2,
  localparam int CLW = $clog2(MAX_CL + 1),
  localparam int RCW = $clog2(TRDL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             bank,
  input  logic [COL_W-1:0] col_in,
  input  logic [2:0]       bl_sel,
  input  logic             ilv,
  input  logic [CLW-1:0]   cas_lat,
  output logic [COL_W-1:0] col_out,
  output logic             beat_bank,
  output logic             rd_issue,
  output logic             wr_en,
  output logic             rd_oe,
  output logic             wr_rec_ok
);
  cmd_e             cmd;
  logic             act_q, act_wr_q, act_bank_q;
  logic [COL_W-1:0] act_base_q, act_beat_q;
  logic [RCW-1:0]   rec_cnt_q;

  logic             is_new, kill, cont, done, full;
  logic [COL_W-1:0] base_sel, beat_sel, beat_nxt, blen;

  burst_cmd_dec u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  always_comb begin
    full     = bl_sel[2];
    blen     = COL_W'(1) << bl_sel[1:0];
    is_new   = (cmd == CMD_RD) || (cmd == CMD_WR);
    kill     = act_q && (((cmd == CMD_PRE) && (bank == act_bank_q)) ||
                         ((cmd == CMD_STOP) && full));
    cont     = act_q && !kill && !is_new;
    base_sel = is_new ? col_in : act_base_q;
    beat_sel = is_new ? '0 : act_beat_q;
    beat_nxt = beat_sel + COL_W'(1);
    done     = !full && (beat_nxt == blen);
    rd_issue = (cmd == CMD_RD) || (cont && !act_wr_q);
    wr_en    = (cmd == CMD_WR) || (cont && act_wr_q);
    beat_bank = is_new ? bank : act_bank_q;
  end

  burst_col_gen #(.COL_W(COL_W)) u_col (
    .base  (base_sel),
    .beat  (beat_sel),
    .bl_sel(bl_sel),
    .ilv   (ilv),
    .col   (col_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      act_wr_q   <= 1'b0;
      act_bank_q <= 1'b0;
      act_base_q <= '0;
      act_beat_q <= '0;
    end else if (is_new) begin
      act_q      <= !done;
      act_wr_q   <= (cmd == CMD_WR);
      act_bank_q <= bank;
      act_base_q <= col_in;
      act_beat_q <= beat_nxt;
    end else if (act_q) begin
      if (kill || done) act_q <= 1'b0;
      else              act_beat_q <= beat_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rec_cnt_q <= RCW'(TRDL);
    else if (wr_en)                     rec_cnt_q <= RCW'(1);
    else if (rec_cnt_q < RCW'(TRDL))    rec_cnt_q <= rec_cnt_q + RCW'(1);
  end

  assign wr_rec_ok = !wr_en && (rec_cnt_q >= RCW'(TRDL));

  burst_lat_pipe #(.MAX_CL(MAX_CL)) u_lat (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rd_issue),
    .cl   (cas_lat),
    .dout (rd_oe)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3,
  localparam int CLW = $clog2(MAX_CL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [COL_W-1:0] col_in,
  input logic [CLW-1:0]   cas_lat,
  input logic [COL_W-1:0] col_out,
  input logic             rd_issue,
  input logic             wr_en,
  input logic             rd_oe,
  input logic             wr_rec_ok
);
  logic [MAX_CL-1:0] hist;
  logic              oe_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[MAX_CL-2:0], rd_issue};
  end

  always_comb begin
    oe_exp = 1'b0;
    for (int i = 1; i <= MAX_CL; i++)
      if (int'(cas_lat) == i) oe_exp = hist[i-1];
  end

  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_issue && wr_en));

  a_r4_oe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cas_lat) >= 1 && int'(cas_lat) <= MAX_CL) |-> (rd_oe == oe_exp));

  a_r11_no_ok_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_rec_ok);

  a_r7_read_starts_now: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ras_n && !cas_n && we_n) |-> (rd_issue && col_out == col_in));

  a_r5_write_starts_now: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ras_n && !cas_n && !we_n) |-> (wr_en && col_out == col_in));
endmodule

bind burst_seq burst_seq_chk #(.COL_W(COL_W), .MAX_CL(MAX_CL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .col_in   (col_in),
  .cas_lat  (cas_lat),
  .col_out  (col_out),
  .rd_issue (rd_issue),
  .wr_en    (wr_en),
  .rd_oe    (rd_oe),
  .wr_rec_ok(wr_rec_ok)
);

// File: tb/burst_seq_tb.sv
`timescale 1ns/1ps
module burst_seq_tb_top;
  localparam int COL_W  = 8;
  localparam int MAX_CL = 3;
  localparam int TRDL   = 2;
  localparam int CLW    = $clog2(MAX_CL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, bank = 1'b0;
  logic [COL_W-1:0] col_in = '0;
  logic [2:0] bl_sel = 3'd2;
  logic ilv = 1'b0;
  logic [CLW-1:0] cas_lat = CLW'(2);
  logic [COL_W-1:0] col_out;
  logic beat_bank, rd_issue, wr_en, rd_oe, wr_rec_ok;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  burst_seq #(.COL_W(COL_W), .MAX_CL(MAX_CL), .TRDL(TRDL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank(bank), .col_in(col_in), .bl_sel(bl_sel), .ilv(ilv),
    .cas_lat(cas_lat), .col_out(col_out), .beat_bank(beat_bank),
    .rd_issue(rd_issue), .wr_en(wr_en), .rd_oe(rd_oe), .wr_rec_ok(wr_rec_ok)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // 0 nop, 1 read, 2 write, 3 precharge, 4 stop, 5 deselected read pattern
  task automatic drv(int op, logic b, int c);
    bank = b;
    col_in = COL_W'(c);
    case (op)
      1: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      2: {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      3: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      4: {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      5: {cs_n, ras_n, cas_n, we_n} = 4'b1101;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
  endtask

  function automatic int ecol(int s, int i, int bl, int il);
    int n, lo;
    n = 1 << bl;
    lo = il ? ((s % n) ^ i) : (((s % n) + i) % n);
    return s - (s % n) + lo;
  endfunction

  task automatic step(int op, logic b, int c);
    @(negedge clk);
    drv(op, b, c);
    #1;
  endtask

  task automatic sweep_one(int isw, int bl, int il, int cl, int s);
    int n;
    n = 1 << bl;
    bl_sel = 3'(bl);
    ilv = 1'(il);
    cas_lat = CLW'(cl);
    for (int c = 0; c < n + MAX_CL + TRDL + 2; c++) begin
      step(c == 0 ? (isw ? 2 : 1) : 0, 1'b0, s);
      if (c < n) chk(il ? "R3 col" : "R2 col", int'(col_out), ecol(s, c, bl, il));
      if (isw) begin
        chk("R5 wr_en", int'(wr_en), int'(c < n));
        chk("R11 rec", int'(wr_rec_ok), int'(c >= n - 1 + TRDL));
      end else begin
        chk("R2 rd_issue", int'(rd_issue), int'(c < n));
        chk("R4 rd_oe", int'(rd_oe), int'(c >= cl && c < cl + n));
      end
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12 rd_issue", int'(rd_issue), 0);
    chk("R12 wr_en", int'(wr_en), 0);
    chk("R12 rd_oe", int'(rd_oe), 0);
    chk("R12 rec", int'(wr_rec_ok), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) step(0, 1'b0, 0);

    // R1: deselected read pattern is a no-op
    cas_lat = CLW'(1);
    bl_sel = 3'd2;
    for (int c = 0; c < 4; c++) begin
      step(c == 0 ? 5 : 0, 1'b0, 7);
      chk("R1 deselect rd_issue", int'(rd_issue), 0);
      chk("R1 deselect rd_oe", int'(rd_oe), 0);
    end

    // R1 R2 R3 R4 R5 R11 sweep
    for (int isw = 0; isw < 2; isw++)
      for (int bl = 0; bl < 4; bl++)
        for (int il = 0; il < 2; il++)
          for (int cl = 1; cl <= MAX_CL; cl++)
            for (int k = 0; k < 4; k++)
              sweep_one(isw, bl, il, cl, (k * 37 + 3) % 256);

    // R6: gapless read chain
    bl_sel = 3'd2; ilv = 1'b0; cas_lat = CLW'(2);
    for (int c = 0; c < 12; c++) begin
      step(c == 0 ? 1 : (c == 4 ? 1 : 0), 1'b0, c == 0 ? 5 : 9);
      if (c < 8) begin
        chk("R6 rd_issue", int'(rd_issue), 1);
        chk("R6 col", int'(col_out), c < 4 ? ecol(5, c, 2, 0) : ecol(9, c - 4, 2, 0));
      end
      chk("R6 rd_oe", int'(rd_oe), int'(c >= 2 && c < 10));
    end

    // R7: write interrupts read
    bl_sel = 3'd3;
    for (int c = 0; c < 13; c++) begin
      step(c == 0 ? 1 : (c == 3 ? 2 : 0), 1'b1, c == 0 ? 0 : 20);
      chk("R7 rd_issue", int'(rd_issue), int'(c < 3));
      chk("R7 wr_en", int'(wr_en), int'(c >= 3 && c < 11));
      if (c >= 3 && c < 11) chk("R7 col", int'(col_out), ecol(20, c - 3, 3, 0));
      chk("R7 rd_oe", int'(rd_oe), int'(c >= 2 && c < 5));
    end

    // R8: precharge same bank ends write; R11 recovery after cut
    for (int c = 0; c < 9; c++) begin
      step(c == 0 ? 2 : (c == 3 ? 3 : 0), 1'b0, 0);
      chk("R8 same bank wr_en", int'(wr_en), int'(c < 3));
      chk("R11 cut rec", int'(wr_rec_ok), int'(c >= 2 + TRDL));
    end
    // R8: precharge other bank ignored
    for (int c = 0; c < 10; c++) begin
      step(c == 0 ? 2 : (c == 3 ? 3 : 0), c == 3 ? 1'b1 : 1'b0, 0);
      chk("R8 other bank wr_en", int'(wr_en), int'(c < 8));
    end

    // R9: stop ignored with finite length
    bl_sel = 3'd2;
    for (int c = 0; c < 7; c++) begin
      step(c == 0 ? 1 : (c == 1 ? 4 : 0), 1'b0, 8);
      chk("R9 finite stop ignored", int'(rd_issue), int'(c < 4));
    end

    // R10 R9: full page wraps and runs until stop
    bl_sel = 3'd4; ilv = 1'b1; cas_lat = CLW'(2);
    for (int c = 0; c < 300; c++) begin
      step(c == 0 ? 1 : 0, 1'b0, 254);
      chk("R10 full rd_issue", int'(rd_issue), 1);
      chk("R10 full col", int'(col_out), (254 + c) % 256);
    end
    step(4, 1'b0, 0);
    chk("R9 stop no beat", int'(rd_issue), 0);
    chk("R9 stop oe drain", int'(rd_oe), 1);
    step(0, 1'b0, 0);
    chk("R9 stop ended", int'(rd_issue), 0);
    chk("R9 stop oe last", int'(rd_oe), 1);
    step(0, 1'b0, 0);
    chk("R9 stop oe off", int'(rd_oe), 0);

    repeat (3) step(0, 1'b0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule